// File: doc/BRIEF.md
# Line code violation counter

This block watches a decoded bipolar receive stream and counts line-coding errors in a saturating 16-bit register. On each valid bit, a positive-mark and a negative-mark strobe describe the received symbol. The substitution decoder upstream supplies a flag that marks bits belonging to a zero-substitution codeword. Configuration inputs choose the line type (T1 or E1), whether zero substitution is in use, whether excessive-zero runs are counted (T1), and whether true code violations are counted instead of bipolar violations (E1).

The error definition follows the configuration. It can be plain bipolar violations, bipolar violations minus those inside substitution codewords, bipolar violations plus excessive-zero runs, or code violations. Counting never stops for framing state. The counter update logic reads the block through two pulses: a latch pulse copies the running count into a snapshot output, and a clear pulse zeroes the running count. Both pulses in one cycle give read-and-clear.

Top module: `lcv_counter`

## Requirements
- R1: A bipolar violation (BPV) is a mark on a valid bit whose polarity equals that of the previous mark. A bit with `pos_mark_i` high is a positive mark, even when `neg_mark_i` is also high. A bit with only `neg_mark_i` high is a negative mark. The first mark after reset is never a BPV.
- R2: When code-violation counting is not selected, each BPV adds 1 to the count. The exception is R3.
- R3: With `subst_en_i`=1 and code-violation counting not selected, a BPV on a bit with `codeword_i`=1 adds nothing.
- R4: With `e1_mode_i`=0 and `exz_en_i`=1, a run of zero bits adds 1 when it reaches 16 zeros (`subst_en_i`=0) or 8 zeros (`subst_en_i`=1). It adds 1 once per run, and counting rearms only after a mark. With `e1_mode_i`=1, zero runs never count.
- R5: With `e1_mode_i`=1 and `cv_mode_i`=1, only code violations count. A code violation is a BPV whose polarity equals that of the previous BPV. `subst_en_i` and `codeword_i` are then ignored.
- R6: A cycle with `bit_valid_i`=0 changes neither the count nor the remembered mark, BPV or zero-run state.
- R7: The count saturates at 65535 and never wraps. Errors arriving in the same bit are summed before saturation.
- R8: `clr_i` zeroes the count at the clock edge where it is sampled, and this overrides any increment from that cycle.
- R9: `latch_i` loads `snap_o` with the count as it stood before that edge. `snap_o` otherwise holds its value.
- R10: After reset `count_o` and `snap_o` are 0 and no previous mark or BPV is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Current strobes describe one received bit |
| pos_mark_i | input | 1 | Positive mark received |
| neg_mark_i | input | 1 | Negative mark received |
| codeword_i | input | 1 | Current bit is part of a substitution codeword |
| e1_mode_i | input | 1 | 1: E1 line, 0: T1 line |
| subst_en_i | input | 1 | Zero-substitution decoding in use |
| exz_en_i | input | 1 | Count excessive-zero runs (T1) |
| cv_mode_i | input | 1 | Count code violations (E1) |
| clr_i | input | 1 | Zero the running count |
| latch_i | input | 1 | Copy running count to snapshot |
| count_o | output | 16 | Running saturating error count |
| snap_o | output | 16 | Snapshot of the count |

## Verification
Every error event, clear and latch takes effect at the clock edge that samples the bit. `count_o` and `snap_o` therefore show the result one register stage after the stimulus, with no extra pipeline delay. The bench drives each bit on the falling edge and advances its behavioural model on the rising edge. It compares both outputs 1 ns after that rising edge, once on every clock. Directed sequences add literal-delta checks for the codeword exemption, run thresholds, code-violation polarity, invalid bits and saturation.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned INC_W = 2;
endpackage

// File: rtl/lcv_bpv_detect.sv
module lcv_bpv_detect
  import lcv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic mark_o,
  output logic bpv_o,
  output logic cv_o
);
  logic have_mark_q, have_bpv_q;
  pol_e last_pol_q, last_bpv_pol_q;
  pol_e pol;

  assign mark_o = valid_i & (pos_i | neg_i);
  assign pol    = pos_i ? POL_POS : POL_NEG;
  assign bpv_o  = mark_o & have_mark_q & (pol == last_pol_q);
  assign cv_o   = bpv_o & have_bpv_q & (pol == last_bpv_pol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_mark_q    <= 1'b0;
      last_pol_q     <= POL_NEG;
      have_bpv_q     <= 1'b0;
      last_bpv_pol_q <= POL_NEG;
    end else begin
      if (mark_o) begin
        have_mark_q <= 1'b1;
        last_pol_q  <= pol;
      end
      if (bpv_o) begin
        have_bpv_q     <= 1'b1;
        last_bpv_pol_q <= pol;
      end
    end
  end

  // R6
  hold_on_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(last_pol_q) && $stable(have_mark_q) && $stable(last_bpv_pol_q));
endmodule

// File: rtl/lcv_zero_run.sv
module lcv_zero_run #(
  parameter int unsigned LONG_RUN  = 16,
  parameter int unsigned SHORT_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic mark_i,
  input  logic short_sel_i,
  input  logic en_i,
  output logic exz_o
);
  localparam int unsigned RUN_W = $clog2(LONG_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(LONG_RUN);
  localparam logic [RUN_W-1:0] LONG_HIT  = RUN_W'(LONG_RUN - 1);
  localparam logic [RUN_W-1:0] SHORT_HIT = RUN_W'(SHORT_RUN - 1);

  logic [RUN_W-1:0] run_q;
  logic zero_bit;

  assign zero_bit = valid_i & ~mark_i;
  // fires only on the zero that completes the run; run keeps growing past it
  assign exz_o = en_i & zero_bit & (run_q == (short_sel_i ? SHORT_HIT : LONG_HIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (valid_i) begin
      if (mark_i) run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  // R4
  exz_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exz_o |=> !exz_o);
  // R6
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(run_q));
endmodule

// File: rtl/lcv_sat_count.sv
module lcv_sat_count
  import lcv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, snap_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, count_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      snap_q  <= '0;
    end else begin
      if (clr_i)         count_q <= '0;
      else if (sum[CNT_W]) count_q <= CNT_MAX;
      else               count_q <= sum[CNT_W-1:0];
      if (latch_i) snap_q <= count_q;
    end
  end

  assign count_o = count_q;
  assign snap_o  = snap_q;

  // R7
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX) && !clr_i |=> count_q == CNT_MAX);
  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> count_q >= $past(count_q));
  // R8
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_q == '0);
  // R9
  snap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> snap_q == $past(count_q));
  // R9
  snap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(snap_q));
endmodule

// File: rtl/lcv_counter.sv
module lcv_counter
  import lcv_pkg::*;
#(
  parameter int unsigned T1_LONG_RUN  = 16,
  parameter int unsigned T1_SHORT_RUN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             pos_mark_i,
  input  logic             neg_mark_i,
  input  logic             codeword_i,
  input  logic             e1_mode_i,
  input  logic             subst_en_i,
  input  logic             exz_en_i,
  input  logic             cv_mode_i,
  input  logic             clr_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o
);
  logic mark, bpv, cv, exz;
  logic cv_sel, code_err;
  logic [INC_W-1:0] inc;

  lcv_bpv_detect u_bpv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bit_valid_i),
    .pos_i   (pos_mark_i),
    .neg_i   (neg_mark_i),
    .mark_o  (mark),
    .bpv_o   (bpv),
    .cv_o    (cv)
  );

  lcv_zero_run #(
    .LONG_RUN  (T1_LONG_RUN),
    .SHORT_RUN (T1_SHORT_RUN)
  ) u_zrun (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (bit_valid_i),
    .mark_i      (mark),
    .short_sel_i (subst_en_i),
    .en_i        (~e1_mode_i & exz_en_i),
    .exz_o       (exz)
  );

  assign cv_sel   = e1_mode_i & cv_mode_i;
  assign code_err = cv_sel ? cv : (bpv & ~(subst_en_i & codeword_i));
  assign inc      = {1'b0, code_err} + {1'b0, exz};

  lcv_sat_count u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .clr_i   (clr_i),
    .latch_i (latch_i),
    .count_o (count_o),
    .snap_o  (snap_o)
  );

  // R3
  codeword_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cv_sel && subst_en_i && codeword_i && mark && !clr_i |=> $stable(count_o));
  // R6
  invalid_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i && !clr_i |=> $stable(count_o));
endmodule

// File: tb/lcv_counter_tb.sv
`timescale 1ns/1ps
module lcv_counter_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic v = 0, p = 0, n = 0, cw = 0, e1 = 0, sub = 0, exz = 0, cvm = 0, clr = 0, lat = 0;
  logic [15:0] count_o, snap_o;
  int total = 0, bad = 0;
  string tag = "R10";

  // reference state
  int last_pol = -1, last_bpv = -1, zrun = 0, m_cnt = 0, m_snap = 0;

  always #2.5 clk = ~clk;

  lcv_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(v), .pos_mark_i(p), .neg_mark_i(n),
    .codeword_i(cw), .e1_mode_i(e1), .subst_en_i(sub), .exz_en_i(exz), .cv_mode_i(cvm),
    .clr_i(clr), .latch_i(lat), .count_o(count_o), .snap_o(snap_o)
  );

  task automatic chk(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  task automatic model_step();
    int inc = 0;
    if (v) begin
      if (p || n) begin
        int pol = p ? 1 : 0;
        if (last_pol == pol) begin
          if (e1 && cvm) begin
            if (last_bpv == pol) inc++;
          end else if (!(sub && cw)) inc++;
          last_bpv = pol;
        end
        last_pol = pol;
        zrun = 0;
      end else begin
        if (zrun < 16) begin
          zrun++;
          if (!e1 && exz && zrun == (sub ? 8 : 16)) inc++;
        end
      end
    end
    if (lat) m_snap = m_cnt;
    if (clr) m_cnt = 0;
    else m_cnt = (m_cnt + inc > 65535) ? 65535 : m_cnt + inc;
  endtask

  task automatic cyc(input logic iv, ip, in_, icw, iclr = 0, ilat = 0);
    @(negedge clk);
    v = iv; p = ip; n = in_; cw = icw; clr = iclr; lat = ilat;
    @(posedge clk);
    model_step();
    #1;
    chk({tag, " count"}, count_o, m_cnt);
    chk({tag, " snap"}, snap_o, m_snap);
  endtask

  task automatic cfg(input logic ie1, isub, iexz, icvm);
    e1 = ie1; sub = isub; exz = iexz; cvm = icvm;
  endtask

  task automatic rnd(input int cycles, input int zero_pct);
    for (int i = 0; i < cycles; i++) begin
      int r = $urandom_range(99);
      logic mk = (r >= zero_pct);
      logic pp = mk & $urandom_range(1);
      logic nn = mk & (~pp | ($urandom_range(7) == 0));
      cyc($urandom_range(9) != 0, pp, nn, $urandom_range(1), $urandom_range(60) == 0,
          $urandom_range(30) == 0);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk("R10 reset count", count_o, 0);
    chk("R10 reset snap", snap_o, 0);

    // R1: first mark never BPV, alternation clean, repeat polarity is one BPV
    tag = "R1"; cfg(0, 0, 0, 0);
    cyc(1, 1, 0, 0); cyc(1, 0, 1, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    chk("R1 one bpv", count_o, 1);
    cyc(1, 1, 1, 0); // both high = positive mark
    chk("R1 both-high positive", count_o, 2);

    tag = "R2"; rnd(400, 40);

    // R3: codeword bpv exempt when substitution on
    tag = "R3"; cfg(0, 1, 0, 0);
    cyc(1, 0, 1, 0); c0 = count_o;
    cyc(1, 0, 1, 1);
    chk("R3 codeword bpv skipped", count_o, c0);
    cyc(1, 0, 1, 0);
    chk("R3 plain bpv counted", count_o, c0 + 1);
    rnd(400, 40);

    // R4: long run threshold, once per run
    tag = "R4"; cfg(0, 0, 1, 0);
    cyc(1, 1, 0, 0); c0 = count_o;
    for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0);
    chk("R4 15 zeros", count_o, c0);
    cyc(1, 0, 0, 0);
    chk("R4 16th zero", count_o, c0 + 1);
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0);
    chk("R4 once per run", count_o, c0 + 1);
    cfg(0, 1, 1, 0);
    cyc(1, 0, 1, 0); c0 = count_o;
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0);
    chk("R4 short run 8", count_o, c0 + 1);
    cfg(1, 0, 1, 0);
    cyc(1, 1, 0, 0); c0 = count_o;
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);
    chk("R4 E1 no zero count", count_o, c0);
    cfg(0, 0, 1, 0); rnd(500, 85);
    cfg(0, 1, 1, 0); rnd(500, 80);

    // R5: code violations, codeword ignored
    tag = "R5"; cfg(1, 1, 0, 1);
    cyc(1, 0, 1, 1); cyc(1, 0, 1, 1); c0 = count_o;
    cyc(1, 0, 1, 1);
    chk("R5 same-pol bpv is cv", count_o, c0 + 1);
    cyc(1, 1, 0, 1); cyc(1, 1, 0, 1);
    chk("R5 alternate bpv no cv", count_o, c0 + 1);
    cyc(1, 1, 0, 1);
    chk("R5 second cv", count_o, c0 + 2);
    rnd(500, 30);

    // R6: invalid bits ignored
    tag = "R6"; cfg(0, 0, 1, 0);
    cyc(1, 1, 0, 0); c0 = count_o;
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 0);
    chk("R6 invalid no effect", count_o, c0);
    cyc(1, 1, 0, 0);
    chk("R6 polarity kept across invalid", count_o, c0 + 1);

    // R8, R9
    tag = "R8";
    cyc(1, 1, 0, 0); c0 = count_o;
    cyc(1, 1, 0, 0, 1, 1);
    chk("R8 clear beats bpv", count_o, 0);
    chk("R9 snap pre-clear", snap_o, c0);
    tag = "R9";
    cyc(1, 1, 0, 0);
    chk("R9 snap held", snap_o, c0);

    // R7: saturation
    tag = "R7"; cfg(0, 0, 0, 0);
    for (int i = 0; i < 65600; i++) cyc(1, 1, 0, 0);
    chk("R7 saturated", count_o, 65535);
    cyc(1, 1, 0, 0, 0, 1);
    chk("R7 snap at max", snap_o, 65535);

    tag = "R2";
    cfg(0, 1, 1, 0); rnd(800, 50);
    cfg(1, 1, 0, 0); rnd(800, 40);
    cfg(1, 0, 0, 1); rnd(800, 40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule